// File: doc/BRIEF.md
# Round-Robin Ring Arbiter

This block shares one resource among a parameterised number of requesters. Each requester has a slice in a ring. In every cycle exactly one slice holds priority, and a carry ripples from that slice to the next, wrapping from the last slice back to the first, until it meets an active request. That request is granted. A slice that has the priority or an incoming carry but no request hands the carry on to the following slice.

A one-hot register remembers the slice after the most recent winner. That slice starts the ring in the following cycle. When no request is present, the register keeps its value. The grant is combinational from the request vector and the register, so the grant path can glitch. Requests must therefore be launched, and grants captured, by flops on the same clock as the arbiter.

Top module: `rr_ring_arbiter`

## Requirements
- R1: While `rst_n` is low, the priority register is asynchronously set to slice 0 (bit 0 of the one-hot pointer). As a result, the first decision after reset with every request high grants slice 0 (grant = 1 << 0).
- R2: `grant` is one-hot when at least one bit of `req` is high, and all zeros when `req` is all zeros.
- R3: No grant bit is high unless the matching `req` bit is high.
- R4: When the slice that holds priority is requesting, it receives the grant.
- R5: Otherwise the grant goes to the first requesting slice found by counting upward from the priority slice, wrapping from slice NUM_REQ-1 to slice 0.
- R6: On a clock edge where slice k is granted, priority moves to slice (k+1) mod NUM_REQ, so slice NUM_REQ-1 hands priority to slice 0.
- R7: On a clock edge with no grant, the priority pointer keeps its value.
- R8: With all requests held high, grants visit slices 0, 1, ..., NUM_REQ-1 in order, one per cycle, and then repeat.
- R9: A requester that holds its request high is granted after at most NUM_REQ-1 grants to other slices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_REQ | Request vector, one bit per slice |
| grant | output | NUM_REQ | Combinational one-hot grant vector |

## Verification
The assertions assume that `req` changes only in step with `clk` and is stable at each rising edge, because the grant is a combinational function of it and is sampled there. They also assume that `rst_n` is driven low before the first edge, so that the pointer starts one-hot. The bench meets these conditions by changing `req` only on falling edges, releasing reset on a falling edge, and reading `grant` a short delay after each change, well before the next rising edge.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

  // One ring slice: a grant is issued when the slice requests and is either
  // the priority holder or is reached by a live carry.
  function automatic logic slice_win(input logic rq, input logic pr, input logic ci);
    return rq & (pr | ci);
  endfunction

  // A slice without a request forwards whatever reached it.
  function automatic logic slice_pass(input logic rq, input logic pr, input logic ci);
    return (pr | ci) & ~rq;
  endfunction

endpackage

// File: rtl/rr_carry_ring.sv
module rr_carry_ring
  import rr_arb_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic [NUM_REQ-1:0] req,
  input  logic [NUM_REQ-1:0] prio,
  output logic [NUM_REQ-1:0] grant
);

  localparam int LAST = NUM_REQ - 1;

  // The ring is unrolled into two laps, so there is no combinational loop.
  // Lap one finds out whether a carry leaves the top slice. Lap two feeds
  // that wrap carry into slice 0 and produces the grants.
  logic wrap_carry;

  always_comb begin
    logic c;
    c = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      c = slice_pass(req[i], prio[i], c);
    end
    wrap_carry = c;
  end

  always_comb begin
    logic c;
    c = wrap_carry;
    grant = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      grant[i] = slice_win(req[i], prio[i], c);
      c        = slice_pass(req[i], prio[i], c);
    end
  end

  // Guards on the combinational result
  always_comb begin
    if ($onehot(prio)) begin
      AST_RING_ONEHOT: assert ($onehot0(grant)) else $error("ring multi-grant"); // R2
      AST_RING_SUBSET: assert ((grant & ~req) == '0) else $error("grant w/o req"); // R3
      AST_RING_LIVE:   assert ((|req) == (|grant)) else $error("idle ring with req"); // R2
    end
  end

  if (LAST < 1) begin : g_bad_width
    initial $error("NUM_REQ must be at least 2");
  end

endmodule

// File: rtl/rr_next_ptr.sv
module rr_next_ptr #(
  parameter int NUM_REQ = 4
) (
  input  logic [NUM_REQ-1:0] grant,
  output logic [NUM_REQ-1:0] ptr_next,
  output logic               advance
);

  localparam int LAST = NUM_REQ - 1;

  // The slice after the winner takes priority; the top slice wraps to slice 0.
  always_comb begin
    ptr_next = {grant[LAST-1:0], grant[LAST]};
    advance  = |grant;
  end

endmodule

// File: rtl/rr_ptr_reg.sv
module rr_ptr_reg #(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [NUM_REQ-1:0] ptr_d,
  output logic [NUM_REQ-1:0] ptr_q
);

  localparam logic [NUM_REQ-1:0] PTR_RESET = NUM_REQ'(1);

  logic [NUM_REQ-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt = ptr_q;
    if (load_en) begin
      ptr_nxt = ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= PTR_RESET;
    end else begin
      ptr_q <= ptr_nxt;
    end
  end

  AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(ptr_q)) else $error("pointer lost one-hot"); // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(ptr_q)) else $error("pointer moved idle"); // R7
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (ptr_q == $past(ptr_d))) else $error("pointer load lost"); // R6

endmodule

// File: rtl/rr_ring_arbiter.sv
module rr_ring_arbiter #(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] grant
);

  localparam int LAST = NUM_REQ - 1;

  logic [NUM_REQ-1:0] prio;
  logic [NUM_REQ-1:0] prio_next;
  logic               prio_adv;

  rr_carry_ring #(.NUM_REQ(NUM_REQ)) u_ring (
    .req   (req),
    .prio  (prio),
    .grant (grant)
  );

  rr_next_ptr #(.NUM_REQ(NUM_REQ)) u_next (
    .grant    (grant),
    .ptr_next (prio_next),
    .advance  (prio_adv)
  );

  rr_ptr_reg #(.NUM_REQ(NUM_REQ)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (prio_adv),
    .ptr_d   (prio_next),
    .ptr_q   (prio)
  );

  AST_PRIO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req & prio)) |-> (grant == prio)) else $error("priority slice skipped"); // R4
  AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    grant[LAST] |=> prio[0]) else $error("no wrap to slice 0"); // R6
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)) else $error("grant not one-hot"); // R2

endmodule

// File: tb/sim_rr_ring_arbiter.sv
`timescale 1ns/1ps
module sim_rr_ring_arbiter;

  localparam int N = 4;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req;
  logic [N-1:0] grant;

  int checks;
  int errors;
  int model_ptr;
  bit done;

  rr_ring_arbiter #(.NUM_REQ(N)) u0 (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .grant (grant)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [N-1:0] ref_grant(input logic [N-1:0] r, input int p);
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (p + k) % N;
      if (r[idx]) return N'(1) << idx;
    end
    return '0;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, check the combinational grant, then advance
  // the model pointer at the rising edge.
  task automatic step(input logic [N-1:0] r, input string tag);
    logic [N-1:0] e;
    @(negedge clk);
    req = r;
    #1;
    e = ref_grant(r, model_ptr);
    check(tag, grant, e);
    check("R3 subset", grant & ~r, '0);
    @(posedge clk);
    for (int i = 0; i < N; i++) if (e[i]) model_ptr = (i + 1) % N;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req   = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_ptr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    step('1, "R1 first grant after reset");
  endtask

  task automatic t_rotate();
    do_reset();
    for (int c = 0; c < 3 * N; c++) begin
      @(negedge clk);
      req = '1;
      #1;
      check("R8 rotation", grant, N'(1) << (c % N));
      @(posedge clk);
    end
    model_ptr = 0;
  endtask

  task automatic t_idle_hold();
    do_reset();
    step(4'b0010, "R4 single req");
    step(4'b0000, "R2 idle zero");
    step(4'b0000, "R2 idle zero");
    step(4'b1111, "R7 pointer held");
    check("R7 pointer at 2", N'(1) << ((model_ptr + N - 1) % N), 4'b0100);
  endtask

  task automatic t_wrap();
    do_reset();
    step(4'b1000, "R4 top slice");
    step(4'b1111, "R6 wrap to 0");
    step(4'b1101, "R5 skip to 2");
    step(4'b0011, "R5 wrap search");
  endtask

  task automatic t_search();
    logic [N-1:0] pat;
    do_reset();
    pat = 4'b1011;
    for (int c = 0; c < 40; c++) begin
      pat = {pat[N-2:0], pat[N-1] ^ pat[0] ^ c[0]};
      step(pat, "R5 pattern");
    end
  endtask

  task automatic t_starve();
    logic [N-1:0] pat;
    int others;
    do_reset();
    step(4'b0100, "R4 setup");
    pat = 4'b0101;
    others = 0;
    for (int c = 0; c < 30; c++) begin
      logic [N-1:0] r;
      pat = {pat[N-2:0], pat[N-1] ^ pat[1]};
      r = pat | 4'b0001;
      @(negedge clk);
      req = r;
      #1;
      check("R9 expected", grant, ref_grant(r, model_ptr));
      if (grant[0]) begin
        checks++;
        if (others > N - 1) begin
          errors++;
          $display("FAIL R9: actual %0d waits expected <= %0d", others, N - 1);
        end
        others = 0;
      end else if (grant != '0) begin
        others++;
      end
      @(posedge clk);
      for (int i = 0; i < N; i++) if (grant[i]) model_ptr = (i + 1) % N;
    end
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    t_reset();
    t_rotate();
    t_idle_hold();
    t_wrap();
    t_search();
    t_starve();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule